// File: doc/BRIEF.md
# Phase-Accumulator Frequency Synthesizer

This block turns a fixed reference clock into a slower clock of programmable frequency. A 16-bit control word is loaded through byte-wide register writes. An effective increment derived from that word is added to a 16-bit phase accumulator on every reference clock while the channel runs. The top bit of the accumulator is the variable-frequency square wave. A one-cycle pulse marks each rising edge of that bit, so a downstream pulse-width stage can use it as its counting enable.

The output frequency is the effective increment times the reference frequency divided by 65536. Words below 0x8000 are used as they are. Words from 0x8000 upward are replaced by their 16-bit two's complement, so 0x8000 maps to itself and 0xFFFF maps to 1. A power-of-two increment gives an exact 50% duty square wave. The useful range when the block clocks a pulse-width stage is 1 to 32768. Each channel has its own instance.

Top module: `nco_clkgen`

## Requirements
- R1: A synchronous reset clears the accumulator, the committed word, the byte shadow and the tick register. During and right after reset, `ncoOut` and `ncoTick` are 0.
- R2: A write with `wrSel`=1 (high byte, word bits 15:8) only loads a shadow register. It does not change the increment in use until a low-byte write follows.
- R3: A write with `wrSel`=0 (low byte, word bits 7:0) commits {shadow, `wrData`} as the new word at that clock edge. The new increment is first added at the next edge.
- R4: The effective increment is the word itself when the word is below 0x8000. Otherwise it is (0x10000 − word) mod 0x10000.
- R5: While `start` is 1, the accumulator adds the increment on every clock and wraps modulo 2^16. While `start` is 0, the accumulator and `ncoOut` hold their values and `ncoTick` stays 0.
- R6: `ncoOut` equals bit 15 of the accumulator.
- R7: `ncoTick` is 1 for exactly one clock, in the same cycle as each 0-to-1 change of `ncoOut`, and is 0 at all other times.
- R8: Starting from an accumulator of 0 with a power-of-two increment W, `ncoOut` is high for exactly 32768 of the next 65536 cycles and `ncoTick` pulses exactly W times.
- R9: With a committed word of 0, `ncoOut` stays low while the channel runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run enable for the accumulator |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Byte lane select: 1 = high byte, 0 = low byte (commits) |
| wrData | input | 8 | Byte to write |
| ncoOut | output | 1 | Variable-frequency square wave (accumulator MSB) |
| ncoTick | output | 1 | One-cycle pulse on each rising edge of ncoOut |

## Verification
The assertions assume that reset is held for at least two clocks before it is released. This ensures the output has a defined low value before any history-based property looks back at it. They also assume that `start` and the write inputs are stable across each rising edge. The stimulus changes every input just after a falling edge and holds reset for three cycles at the start of every scenario. The full-wrap duty and tick-count checks rely on starting from a cleared accumulator, so each of those runs begins with its own reset and word load.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int BYTE_W     = 8;
  localparam int BYTE_COUNT = 2;
  localparam int WORD_W     = BYTE_W * BYTE_COUNT;
  localparam int SEL_W      = (BYTE_COUNT > 1) ? $clog2(BYTE_COUNT) : 1;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic              advance;
    logic [WORD_W-1:0] incr;
  } ncoStrobe_t;
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [BYTE_W-1:0] wrData,
  output ncoStrobe_t        strobe
);
  localparam logic [SEL_W-1:0] COMMIT_LANE = '0;

  logic [WORD_W-1:BYTE_W] shadowHi;
  logic [WORD_W-1:0]      ctrlWord;
  logic [WORD_W-1:0]      effIncr;

  // One shadow byte per upper lane; lane 0 is the committing lane.
  for (genvar lane = 1; lane < BYTE_COUNT; lane++) begin : gLane
    localparam logic [SEL_W-1:0] LANE_ID = SEL_W'(lane);
    logic [BYTE_W-1:0] laneReg;
    always_ff @(posedge clk) begin
      if (rst) laneReg <= '0;
      else if (wrEn && wrSel == LANE_ID) laneReg <= wrData;
    end
    assign shadowHi[lane*BYTE_W +: BYTE_W] = laneReg;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrlWord <= '0;
    else if (wrEn && wrSel == COMMIT_LANE) ctrlWord <= {shadowHi, wrData};
  end

  // Words with the top bit set are folded to their two's complement.
  always_comb begin
    if (ctrlWord[WORD_W-1]) effIncr = (~ctrlWord) + WORD_W'(1);
    else                    effIncr = ctrlWord;
  end

  assign strobe.advance = start;
  assign strobe.incr    = effIncr;
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ncoStrobe_t strobe,
  output logic       phaseMsb,
  output logic       riseTick
);
  logic [WORD_W-1:0] phaseAcc;
  logic [WORD_W-1:0] phaseNext;

  assign phaseNext = phaseAcc + strobe.incr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc <= '0;
      riseTick <= 1'b0;
    end else if (strobe.advance) begin
      phaseAcc <= phaseNext;
      riseTick <= phaseNext[WORD_W-1] & ~phaseAcc[WORD_W-1];
    end else begin
      riseTick <= 1'b0;
    end
  end

  assign phaseMsb = phaseAcc[WORD_W-1];
endmodule

// File: rtl/nco_clkgen.sv
module nco_clkgen
  import nco_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [BYTE_W-1:0] wrData,
  output logic              ncoOut,
  output logic              ncoTick
);
  ncoStrobe_t strobe;

  nco_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .strobe (strobe)
  );

  nco_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .phaseMsb (ncoOut),
    .riseTick (ncoTick)
  );
endmodule

// File: rtl/nco_clkgen_chk.sv
module nco_clkgen_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic ncoOut,
  input logic ncoTick
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!ncoOut && !ncoTick)); // R1

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(ncoOut) && !ncoTick)); // R5

  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    ncoTick |-> (ncoOut && !$past(ncoOut))); // R7

  AST_RISE_GIVES_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(ncoOut) |-> ncoTick); // R7

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ncoTick |=> !ncoTick); // R7
endmodule

bind nco_clkgen nco_clkgen_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .ncoOut  (ncoOut),
  .ncoTick (ncoTick)
);

// File: tb/nco_clkgen_tb.sv
module nco_clkgen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       wrEn = 1'b0;
  logic [0:0] wrSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       ncoOut;
  logic       ncoTick;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit cmpOn = 0;

  // Reference state built from the requirements.
  int mAcc = 0;
  int mWord = 0;
  int mShadow = 0;
  bit mTick = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_clkgen u_dut (
    .clk(clk), .rst(rst), .start(start), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .ncoOut(ncoOut), .ncoTick(ncoTick)
  );

  function automatic int effW(int w);
    if (w < 32768) return w;
    return (65536 - w) % 65536;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mAcc <= 0; mWord <= 0; mShadow <= 0; mTick <= 0;
    end else begin
      if (start) begin
        mAcc  <= (mAcc + effW(mWord)) % 65536;
        mTick <= (((mAcc + effW(mWord)) % 65536) >= 32768) && (mAcc < 32768);
      end else begin
        mTick <= 0;
      end
      if (wrEn) begin
        if (wrSel == 1'b1) mShadow <= int'(wrData);
        else mWord <= mShadow * 256 + int'(wrData);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic adv();
    @(negedge clk);
    if (cmpOn) begin
      check("R6 out", int'(ncoOut), (mAcc >= 32768) ? 1 : 0);
      check("R7 tick", int'(ncoTick), int'(mTick));
    end
  endtask

  task automatic doReset();
    rst = 1'b1; start = 1'b0; wrEn = 1'b0;
    repeat (3) adv();
    rst = 1'b0;
  endtask

  task automatic writeByte(bit hi, int data);
    wrEn = 1'b1; wrSel = hi; wrData = 8'(data);
    adv();
    wrEn = 1'b0;
  endtask

  task automatic loadWord(int w);
    writeByte(1'b1, w / 256);
    writeByte(1'b0, w % 256);
  endtask

  task automatic fullWrap(int w, string req);
    int highCnt;
    int tickCnt;
    highCnt = 0; tickCnt = 0;
    cmpOn = 0;
    doReset();
    loadWord(w);
    start = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      adv();
      if (ncoOut) highCnt++;
      if (ncoTick) tickCnt++;
    end
    start = 1'b0;
    check({req, " duty"}, highCnt, 32768);
    check({req, " ticks"}, tickCnt, effW(w));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int sweep[6];
    sweep = '{16'h8001, 16'hFFFF, 16'h7FFF, 16'h1234, 16'hC000, 16'h00FF};

    // R1: reset state
    doReset();
    check("R1 out after reset", int'(ncoOut), 0);
    check("R1 tick after reset", int'(ncoTick), 0);

    // R9: word 0 keeps the output low while running
    start = 1'b1;
    for (int i = 0; i < 50; i++) begin
      adv();
      check("R9 zero word out", int'(ncoOut), 0);
    end

    // R2: a high-byte write alone changes nothing
    start = 1'b0;
    writeByte(1'b1, 8'hFF);
    start = 1'b1;
    for (int i = 0; i < 300; i++) begin
      adv();
      check("R2 shadow only", int'(ncoOut), 0);
    end
    // The low-byte write commits 0xFF00, so W = 0x0100.
    writeByte(1'b0, 8'h00);
    begin
      int tc;
      tc = 0;
      for (int i = 0; i < 512; i++) begin
        adv();
        if (ncoTick) tc++;
      end
      check("R2 R4 commit after low byte ticks", tc, 2);
    end

    // R3: commit timing
    doReset();
    start = 1'b1;
    writeByte(1'b1, 8'h80);
    writeByte(1'b0, 8'h00);
    check("R3 not yet applied", int'(ncoOut), 0);
    adv();
    check("R3 applied next edge out", int'(ncoOut), 1);
    check("R3 applied next edge tick", int'(ncoTick), 1);
    adv();
    check("R3 R5 wrap out", int'(ncoOut), 0);
    check("R7 tick single", int'(ncoTick), 0);

    // R4 R5 R6 R7: per-cycle comparison over a sweep of words, loaded while running
    doReset();
    cmpOn = 1;
    start = 1'b1;
    for (int b = 0; b < 16; b++) begin
      loadWord(1 << b);
      repeat (150) adv();
    end
    foreach (sweep[k]) begin
      loadWord(sweep[k]);
      repeat (150) adv();
    end

    // R5: hold while stopped
    loadWord(16'h0123);
    repeat (37) adv();
    begin
      int held;
      held = int'(ncoOut);
      start = 1'b0;
      for (int i = 0; i < 40; i++) begin
        adv();
        check("R5 hold out", int'(ncoOut), held);
        check("R5 hold tick", int'(ncoTick), 0);
      end
      start = 1'b1;
      repeat (100) adv();
    end
    cmpOn = 0;

    // R8: exact duty and tick count over one full wrap
    fullWrap(16'h0400, "R8 W=0x400");
    fullWrap(16'hF000, "R8 R4 W=0x1000");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule